// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Edge/Level Sensing

This block turns a set of raw interrupt lines into a registered interrupt request vector. Each line is sensed either on its rising edge or by its level, chosen by a bit in a trigger-mode register. A fixed, per-instance writable mask decides which lines may be switched to level sensing at all. Lines outside the mask always stay in edge mode.

Edge-mode requests are held until the acknowledge logic clears them with a per-line strobe. Level-mode requests simply track the line, one clock late, and ignore the strobe. A synchronous re-initialisation input empties the request vector and forgets the remembered line levels, so a line that is still high afterwards is seen as a fresh edge. The trigger-mode register keeps its value through that re-initialisation. Priority resolution, masking and vector generation belong to neighbouring logic.

Top module: `irq_req_latch`

## Requirements
- R1: While the asynchronous reset is asserted, and until its synchronised release, the request vector and the trigger-mode register read back as all zeros.
- R2: A line in level mode (trigger-mode bit = 1) drives its request bit to the line value seen at the previous clock edge, both high and low.
- R3: A line in edge mode (trigger-mode bit = 0) sets its request bit one clock after it is sampled high when it was sampled low at the clock edge before.
- R4: An edge-mode request bit holds its value while the line is low and no clear strobe is given.
- R5: An edge-mode line that stays high raises no second request after its request has been cleared; a new low-to-high transition is needed.
- R6: A trigger-mode write stores the data ANDed with the parameter WRITABLE_MASK (default 8'hF8). Bit i of the data controls line i. Bits outside the mask read back 0 and those lines stay in edge mode.
- R7: A clear strobe on an edge-mode line with no new edge in the same cycle clears its request bit at the next clock.
- R8: A clear strobe on a level-mode line has no effect; the request bit keeps following the line.
- R9: When a clear strobe and a new edge reach an edge-mode line in the same cycle, the request bit is set at the next clock.
- R10: Asserting reinit clears every request bit and every remembered line level at the next clock and leaves the trigger-mode register unchanged. An edge-mode line still high afterwards raises a new request one clock later.
- R11: A written trigger-mode value reads back on mode_o from the clock after the write and takes effect for sensing from that same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reinit | input | 1 | Synchronous controller re-initialisation |
| line_in | input | NUM_LINES | Raw interrupt line levels |
| mode_wr_en | input | 1 | Trigger-mode register write strobe |
| mode_wr_data | input | NUM_LINES | Trigger-mode write data, 1 = level |
| ack_clr | input | NUM_LINES | Per-line clear strobes from acknowledge logic |
| irr_o | output | NUM_LINES | Registered interrupt request vector |
| mode_o | output | NUM_LINES | Trigger-mode register readback |

## Verification
The remembered previous level is the only state that never reaches a port. A wrong value shows either as a missed request on the next rising line or as a spurious second request after a clear while the line stays high. Both appear on irr_o exactly one clock after the line sample that exposes them. The bench therefore holds lines high across clears, re-initialisations and mode changes. A wrong mode bit or a wrong mask shows directly on mode_o one clock after the write. It also shows on irr_o as soon as a strobe or a falling line meets that line.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;

  // Next request value for one line; re-init handled by the caller.
  function automatic logic next_request(
    input sense_e sense,
    input logic   line_now,
    input logic   line_prev,
    input logic   req_now,
    input logic   clr
  );
    logic nxt;
    if (sense == SENSE_LEVEL) begin
      nxt = line_now;
    end else if (line_now && !line_prev) begin
      nxt = 1'b1;            // new edge beats a clear
    end else if (clr) begin
      nxt = 1'b0;
    end else begin
      nxt = req_now;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/irq_latch_rst_sync.sv
module irq_latch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irq_latch_mode_reg.sv
module irq_latch_mode_reg #(
  parameter int                 NUM_LINES     = 8,
  parameter logic [NUM_LINES-1:0] WRITABLE_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] mode_q
);

  logic [NUM_LINES-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      mode_d = wr_data & WRITABLE_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_en) begin
      mode_q <= mode_d;
    end
  end

  assert_mode_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_q == ($past(wr_data) & WRITABLE_MASK)));

  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));

  assert_mode_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q & ~WRITABLE_MASK) == '0));

endmodule

// File: rtl/irq_latch_line_cell.sv
module irq_latch_line_cell
  import irq_latch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reinit,
  input  logic line,
  input  logic level_mode,
  input  logic clr,
  output logic req_o
);

  logic   req_q;
  logic   prev_q;
  logic   req_d;
  logic   prev_d;
  sense_e sense;

  assign sense = level_mode ? SENSE_LEVEL : SENSE_EDGE;

  always_comb begin
    if (reinit) begin
      req_d  = 1'b0;
      prev_d = 1'b0;
    end else begin
      req_d  = next_request(sense, line, prev_q, req_q, clr);
      prev_d = line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      prev_q <= prev_d;
    end
  end

  assign req_o = req_q;

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !reinit) |=> (req_q == $past(line)));

  assert_edge_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !reinit && line && !prev_q) |=> req_q);

  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !reinit && !line && !clr) |=> $stable(req_q));

  assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !reinit && line && prev_q && clr) |=> !req_q);

  assert_edge_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !reinit && clr && !(line && !prev_q)) |=> !req_q);

  assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !reinit && clr && line && !prev_q) |=> req_q);

  assert_reinit_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (!req_q && !prev_q));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (!req_q && !prev_q);
    end
  end

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int                   NUM_LINES     = 8,
  parameter logic [NUM_LINES-1:0] WRITABLE_MASK = 8'hF8,
  parameter int                   SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reinit,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 mode_wr_en,
  input  logic [NUM_LINES-1:0] mode_wr_data,
  input  logic [NUM_LINES-1:0] ack_clr,
  output logic [NUM_LINES-1:0] irr_o,
  output logic [NUM_LINES-1:0] mode_o
);

  logic                 rst_int_n;
  logic [NUM_LINES-1:0] mode_q;

  irq_latch_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  irq_latch_mode_reg #(
    .NUM_LINES    (NUM_LINES),
    .WRITABLE_MASK(WRITABLE_MASK)
  ) u_mode_reg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (mode_wr_en),
    .wr_data(mode_wr_data),
    .mode_q (mode_q)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irq_latch_line_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .reinit    (reinit),
      .line      (line_in[i]),
      .level_mode(mode_q[i]),
      .clr       (ack_clr[i]),
      .req_o     (irr_o[i])
    );
  end

  assign mode_o = mode_q;

  always @(posedge clk) begin
    if (!rst_int_n) begin
      assert_reset_outputs_R1: assert (irr_o == '0 && mode_o == '0);
    end
  end

  assert_reinit_keeps_mode_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reinit && !mode_wr_en) |=> $stable(mode_o));

endmodule

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;

  localparam int         N    = 8;
  localparam logic [7:0] MASK = 8'hF8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reinit;
  logic [N-1:0] line_in;
  logic         mode_wr_en;
  logic [N-1:0] mode_wr_data;
  logic [N-1:0] ack_clr;
  logic [N-1:0] irr_o;
  logic [N-1:0] mode_o;

  // reference model state
  logic [N-1:0] m_irr;
  logic [N-1:0] m_prev;
  logic [N-1:0] m_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_req_latch #(.NUM_LINES(N), .WRITABLE_MASK(MASK)) u_irq_req_latch (
    .clk(clk), .rst_n(rst_n), .reinit(reinit), .line_in(line_in),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .ack_clr(ack_clr), .irr_o(irr_o), .mode_o(mode_o)
  );

  task automatic check(input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [N-1:0] ni;
    ni = m_irr;
    if (reinit) begin
      ni = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (m_mode[i])                       ni[i] = line_in[i];
        else if (line_in[i] && !m_prev[i])   ni[i] = 1'b1;
        else if (ack_clr[i])                 ni[i] = 1'b0;
      end
    end
    m_prev = reinit ? '0 : line_in;
    m_irr  = ni;
    if (mode_wr_en) m_mode = mode_wr_data & MASK;
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input logic [N-1:0] ln,
                      input logic [N-1:0] ack, input logic ri,
                      input logic we, input logic [N-1:0] wd);
    line_in = ln; ack_clr = ack; reinit = ri;
    mode_wr_en = we; mode_wr_data = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, irr_o, m_irr, "irr");
    check(tag, mode_o, m_mode, "mode");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_irr = '0; m_prev = '0; m_mode = '0;
    rst_n = 1'b0; reinit = 1'b0; line_in = '0; mode_wr_en = 1'b0;
    mode_wr_data = '0; ack_clr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", irr_o, 8'h00, "irr in reset");
    check("R1", mode_o, 8'h00, "mode in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", irr_o, 8'h00, "irr after release");

    // R6 / R11: masked write, readback next clock
    step("R6", 8'h00, 8'h00, 0, 1, 8'hFF);
    check("R6", mode_o, 8'hF8, "masked mode");
    step("R11", 8'h00, 8'h00, 0, 1, 8'hF0);
    check("R11", mode_o, 8'hF0, "mode readback");

    // edge line 0
    step("R3", 8'h01, 8'h00, 0, 0, 8'h00);
    check("R3", irr_o & 8'h01, 8'h01, "edge set");
    step("R4", 8'h00, 8'h00, 0, 0, 8'h00);
    step("R4", 8'h00, 8'h00, 0, 0, 8'h00);
    check("R4", irr_o & 8'h01, 8'h01, "edge held low");
    step("R7", 8'h00, 8'h01, 0, 0, 8'h00);
    check("R7", irr_o & 8'h01, 8'h00, "edge cleared");
    step("R9", 8'h01, 8'h01, 0, 0, 8'h00);
    check("R9", irr_o & 8'h01, 8'h01, "edge beats clear");
    step("R5", 8'h01, 8'h01, 0, 0, 8'h00);
    step("R5", 8'h01, 8'h00, 0, 0, 8'h00);
    step("R5", 8'h01, 8'h00, 0, 0, 8'h00);
    check("R5", irr_o & 8'h01, 8'h00, "no retrigger while high");

    // level line 4
    step("R2", 8'h11, 8'h00, 0, 0, 8'h00);
    check("R2", irr_o & 8'h10, 8'h10, "level high");
    step("R8", 8'h11, 8'h10, 0, 0, 8'h00);
    check("R8", irr_o & 8'h10, 8'h10, "clear ignored in level");
    step("R2", 8'h01, 8'h00, 0, 0, 8'h00);
    check("R2", irr_o & 8'h10, 8'h00, "level low");

    // R10: reinit keeps mode, line 0 still high re-requests
    step("R10", 8'h11, 8'h00, 1, 0, 8'h00);
    check("R10", irr_o, 8'h00, "reinit clears");
    check("R10", mode_o, 8'hF0, "reinit keeps mode");
    step("R10", 8'h11, 8'h00, 0, 0, 8'h00);
    check("R10", irr_o, 8'h11, "fresh edge after reinit");

    // R6: masked-off line 2 stays edge even when written
    step("R6", 8'h00, 8'hFF, 0, 1, 8'h04);
    check("R6", mode_o, 8'h00, "bit 2 not writable");
    step("R6", 8'h04, 8'h00, 0, 0, 8'h00);
    step("R6", 8'h00, 8'h00, 0, 0, 8'h00);
    check("R6", irr_o & 8'h04, 8'h04, "line 2 latched as edge");

    // mixed pseudo-random traffic against the model
    for (int k = 0; k < 400; k++) begin
      step("mixed", 8'($urandom), 8'($urandom), ($urandom % 23) == 0,
           ($urandom % 17) == 0, 8'($urandom));
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule